// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces a single active-low reset for the rest of a system. It has two sources. The first is a digital supply-valid flag that arrives from an external comparator. The second is a watchdog that expects periodic rising edges from a microcontroller. When the supply is bad, reset is asserted at once. Once the supply recovers, reset is held for an extended window. If the watchdog sees no kick within its timeout window, it produces a reset pulse of fixed length.

The watchdog can take its kicks from an external pin, which first passes through a two-flop synchronizer, or from an internal periodic pulse generator. One configuration input selects the source. All durations are parameters counted in system-clock cycles. The defaults suit a 460.8 kHz clock: a hold of about 35 ms, a timeout of about 53 ms, a pulse of about 140 ms, and an internal kick at 1.8 kHz.

The reset output is registered. It is released only when the supply is valid and both hold timers have expired. When a supply-triggered hold and a watchdog pulse overlap, the one that ends later decides when reset is released.

Top module: `reset_supervisor`

## Requirements
- R1: When `supply_ok` is sampled low at a rising clock edge, `reset_n` is low after that edge.
- R2: After the block reset (`arst_n` low, during which `reset_n` is low) or after `supply_ok` returns high, `reset_n` stays low. It goes high on the POR_HOLD_CYC-th consecutive rising edge at which `supply_ok` is sampled high, provided no watchdog pulse is pending.
- R3: With `reset_n` high and no kick taken, `reset_n` goes low on the WDT_TIMEOUT_CYC-th rising edge after the last release of reset or the last kick taken.
- R4: A watchdog reset pulse keeps `reset_n` low for exactly WDT_PULSE_CYC cycles when the supply stays valid.
- R5: With `kick_src_sel` = 1 (internal source), a kick is taken on every rising edge whose index since block reset is a multiple of INT_KICK_PERIOD. The index of the first edge is 1. `kick_pin` has no effect in this mode.
- R6: With `kick_src_sel` = 0 (pin source), only a low-to-high transition of `kick_pin` counts as a kick. A pin held high does not keep the watchdog satisfied.
- R7: Suppose a rising transition of `kick_pin` is first sampled high at edge n. It is taken as a kick at edge n+2. A kick taken on the same edge as the timeout limit prevents the watchdog pulse.
- R8: The timeout count is held at zero while `reset_n` is low, so it restarts from zero each time any reset ends.
- R9: When a supply-triggered hold and a watchdog pulse overlap, `reset_n` goes high only after both have run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| supply_ok | input | 1 | Digital result of the supply comparator; 1 means valid |
| kick_pin | input | 1 | External watchdog kick from the microcontroller (asynchronous) |
| kick_src_sel | input | 1 | Kick source select: 0 = pin, 1 = internal generator |
| reset_n | output | 1 | Registered active-low system reset |

## Verification
The case that needs the most care is a kick that is taken on the same edge as timeout expiry. The bench sets up this case deliberately. It places a pin rising edge so that, after the two synchronizer stages, the edge is consumed exactly at the expiry edge. It then expects `reset_n` to stay high. The second collision is a supply drop during a watchdog pulse, in both orders. In the first order, the hold outlasts the pulse. In the second, the pulse outlasts the hold. A random phase then mixes pin toggles, source switches and supply dropouts. The bench compares `reset_n` on every cycle against a cycle model built from the requirements.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic {
        KICK_FROM_PIN   = 1'b0,
        KICK_FROM_TIMER = 1'b1
    } kick_src_e;

    // bits needed to hold the value max_val
    function automatic int unsigned cnt_bits(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/kick_edge_det.sv
module kick_edge_det #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin,
    output logic rise
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [MSB:0] chain;
        logic         prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[MSB-1:0], pin};
        st_d.prev  = st_q.chain[MSB];
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise = st_q.chain[MSB] & ~st_q.prev;

    generate
        if (SYNC_STAGES == 2) begin : g_chk
            // R7: an edge reported now was sampled high two edges ago, low three ago
            p_sync_delay_r7: assert property (@(posedge clk) disable iff (!arst_n)
                rise |-> ($past(pin, 2) && !$past(pin, 3)));
        end
    endgenerate

endmodule

// File: rtl/int_kick_gen.sv
module int_kick_gen #(
    parameter int unsigned PERIOD = 256
) (
    input  logic clk,
    input  logic arst_n,
    output logic pulse
);
    localparam int unsigned CW = rsv_pkg::cnt_bits(PERIOD - 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] phase;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == LAST) st_d.phase = '0;
        else                    st_d.phase = st_q.phase + CW'(1);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pulse = (st_q.phase == LAST);

    generate
        if (PERIOD > 1) begin : g_chk
            // R5: internal kick is a single-cycle strobe
            p_single_strobe_r5: assert property (@(posedge clk) disable iff (!arst_n)
                pulse |=> !pulse);
        end
    endgenerate

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int unsigned TIMEOUT_CYC = 24422
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clear,
    input  logic kick,
    output logic fire
);
    localparam int unsigned CW = rsv_pkg::cnt_bits(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] elapsed;
    } wdt_st_t;

    wdt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (clear || kick) begin
            st_d.elapsed = '0;
        end else if (st_q.elapsed == LIMIT) begin
            fire         = 1'b1;
            st_d.elapsed = '0;
        end else begin
            st_d.elapsed = st_q.elapsed + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    // R3: the elapsed count never passes the limit
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!arst_n)
        st_q.elapsed <= LIMIT);
    // R8: when reset ends the count starts from zero
    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(clear) |-> (st_q.elapsed == '0));

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int unsigned HOLD_CYC     = 16128,
    parameter bit          START_LOADED = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic load,
    output logic idle_next,
    output logic busy
);
    localparam int unsigned CW = rsv_pkg::cnt_bits(HOLD_CYC);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

    typedef struct packed {
        logic [CW-1:0] remain;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)                   st_d.remain = HOLD_V;
        else if (st_q.remain != '0) st_d.remain = st_q.remain - CW'(1);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q.remain <= START_LOADED ? HOLD_V : '0;
        else         st_q        <= st_d;
    end

    assign idle_next = (st_d.remain == '0);
    assign busy      = (st_q.remain != '0);

    // R2/R4: an unloaded busy timer strictly counts down
    p_counts_down_r2: assert property (@(posedge clk) disable iff (!arst_n)
        (busy && !load) |=> (st_q.remain < $past(st_q.remain)));

endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
    parameter int unsigned POR_HOLD_CYC    = 16128,
    parameter int unsigned WDT_TIMEOUT_CYC = 24422,
    parameter int unsigned WDT_PULSE_CYC   = 64512,
    parameter int unsigned INT_KICK_PERIOD = 256
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok,
    input  logic kick_pin,
    input  logic kick_src_sel,
    output logic reset_n
);
    import rsv_pkg::*;

    typedef struct packed {
        logic released;
    } out_st_t;

    out_st_t out_d, out_q;

    logic ext_rise, tmr_pulse, kick_evt, wd_fire;
    logic por_idle_next, por_busy, wd_idle_next, wd_busy;

    kick_edge_det #(.SYNC_STAGES(2)) u_edge (
        .clk(clk), .arst_n(arst_n), .pin(kick_pin), .rise(ext_rise)
    );

    int_kick_gen #(.PERIOD(INT_KICK_PERIOD)) u_gen (
        .clk(clk), .arst_n(arst_n), .pulse(tmr_pulse)
    );

    assign kick_evt = (kick_src_e'(kick_src_sel) == KICK_FROM_TIMER) ? tmr_pulse : ext_rise;

    wdt_timer #(.TIMEOUT_CYC(WDT_TIMEOUT_CYC)) u_wdt (
        .clk(clk), .arst_n(arst_n), .clear(!out_q.released),
        .kick(kick_evt), .fire(wd_fire)
    );

    hold_timer #(.HOLD_CYC(POR_HOLD_CYC), .START_LOADED(1'b1)) u_por_hold (
        .clk(clk), .arst_n(arst_n), .load(!supply_ok),
        .idle_next(por_idle_next), .busy(por_busy)
    );

    hold_timer #(.HOLD_CYC(WDT_PULSE_CYC), .START_LOADED(1'b0)) u_wd_hold (
        .clk(clk), .arst_n(arst_n), .load(wd_fire),
        .idle_next(wd_idle_next), .busy(wd_busy)
    );

    always_comb begin
        out_d          = out_q;
        out_d.released = supply_ok && por_idle_next && wd_idle_next;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) out_q <= '0;
        else         out_q <= out_d;
    end

    assign reset_n = out_q.released;

    // R1: bad supply asserts reset after the sampling edge
    p_invalid_low_r1: assert property (@(posedge clk) disable iff (!arst_n)
        !supply_ok |=> !reset_n);
    // R4: watchdog expiry pulls reset low
    p_fire_low_r4: assert property (@(posedge clk) disable iff (!arst_n)
        wd_fire |=> !reset_n);
    // R9: release only when both hold timers are empty
    p_release_idle_r9: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(reset_n) |-> (!por_busy && !wd_busy));

endmodule

// File: tb/tb_reset_supervisor.sv
module tb_reset_supervisor;
    localparam int P = 40;
    localparam int T = 60;
    localparam int W = 100;
    localparam int K = 16;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic kick_pin = 1'b0;
    logic kick_src_sel = 1'b0;
    logic reset_n;

    always #2 clk = ~clk;

    reset_supervisor #(
        .POR_HOLD_CYC(P), .WDT_TIMEOUT_CYC(T),
        .WDT_PULSE_CYC(W), .INT_KICK_PERIOD(K)
    ) dut (
        .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok),
        .kick_pin(kick_pin), .kick_src_sel(kick_src_sel), .reset_n(reset_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    // requirement-level cycle model
    int edge_n = 0;
    int m_por = P;
    int m_wd = 0;
    int m_tmo = 0;
    logic m_rn = 1'b0;
    logic [3:0] pin_hist = '0;
    logic m_kick, m_fire;
    string m_tag = "R2";

    function automatic logic kick_taken(input logic sel, input int n, input logic [3:0] h);
        if (sel) return (n % K) == 0;           // R5
        return h[2] && !h[3];                   // R6, R7
    endfunction

    function automatic string cause_tag(input logic sup, input int por, input int wd, input logic fired);
        if (!sup)               return "R1";
        if (por > 0 && wd > 0)  return "R9";
        if (por > 0)            return "R2";
        if (fired)              return "R3";
        if (wd > 0)             return "R4";
        return "R3";
    endfunction

    always @(posedge clk) begin
        if (!arst_n) begin
            edge_n = 0; m_por = P; m_wd = 0; m_tmo = 0; m_rn = 1'b0;
            pin_hist = '0; m_tag = "R2";
        end else begin
            edge_n++;
            pin_hist = {pin_hist[2:0], kick_pin};
            m_kick = kick_taken(kick_src_sel, edge_n, pin_hist);
            m_fire = 1'b0;
            if (!m_rn || m_kick) m_tmo = 0;     // R8
            else if (m_tmo == T - 1) begin m_fire = 1'b1; m_tmo = 0; end
            else m_tmo++;
            if (!supply_ok) m_por = P; else if (m_por > 0) m_por--;
            if (m_fire) m_wd = W; else if (m_wd > 0) m_wd--;
            m_rn = supply_ok && (m_por == 0) && (m_wd == 0);
            m_tag = cause_tag(supply_ok, m_por, m_wd, m_fire);
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: reset_n=%b expected %b (edge %0d)", tag, act, exp, edge_n);
        end
    endtask

    always @(negedge clk) if (checking && arst_n) chk(m_tag, reset_n, m_rn);

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_level(input logic lvl, input int limit);
        for (int i = 0; i < limit && reset_n !== lvl; i++) @(negedge clk);
    endtask

    initial begin
        int sup_left;
        void'($urandom(32'd20240611));
        step(5);
        chk("R2", reset_n, 1'b0);              // low during block reset
        arst_n = 1'b1;
        kick_pin = 1'b1;                       // edge swallowed while in reset
        checking = 1'b1;
        step(P - 1); chk("R2", reset_n, 1'b0);
        step(1);     chk("R2", reset_n, 1'b1);
        // pin held high: no edges
        step(T - 1); chk("R6", reset_n, 1'b1);
        step(1);     chk("R3", reset_n, 1'b0);
        step(W - 1); chk("R4", reset_n, 1'b0);
        step(1);     chk("R4", reset_n, 1'b1);
        step(T - 1); chk("R8", reset_n, 1'b1);
        step(1);     chk("R3", reset_n, 1'b0);
        step(W - 1); chk("R4", reset_n, 1'b0);
        step(1);     chk("R4", reset_n, 1'b1);
        // kick consumed exactly on the expiry edge
        kick_pin = 1'b0;
        step(T - 3); kick_pin = 1'b1;
        step(3);     chk("R7", reset_n, 1'b1);
        step(T - 1); chk("R7", reset_n, 1'b1);
        step(1);     chk("R3", reset_n, 1'b0);
        wait_level(1'b1, 2 * W);
        // periodic pin toggling keeps the system alive
        for (int i = 0; i < 20; i++) begin kick_pin = ~kick_pin; step(20); end
        chk("R6", reset_n, 1'b1);
        // internal source, pin ignored
        kick_src_sel = 1'b1; kick_pin = 1'b0;
        step(400); chk("R5", reset_n, 1'b1);
        for (int i = 0; i < 10; i++) begin kick_pin = ~kick_pin; step(37); end
        chk("R5", reset_n, 1'b1);
        // overlap: supply drop late in a watchdog pulse
        kick_src_sel = 1'b0; kick_pin = 1'b0;
        wait_level(1'b0, 3 * T);
        step(W - 10); supply_ok = 1'b0;
        step(3);      chk("R1", reset_n, 1'b0);
        supply_ok = 1'b1;
        step(P - 1);  chk("R9", reset_n, 1'b0);
        step(1);      chk("R9", reset_n, 1'b1);
        // overlap: supply drop early in a watchdog pulse
        wait_level(1'b0, 3 * T);
        step(5); supply_ok = 1'b0; step(2); supply_ok = 1'b1;
        step(P);      chk("R9", reset_n, 1'b0);
        wait_level(1'b1, 2 * W);
        chk("R9", reset_n, 1'b1);
        // random mix
        sup_left = 0;
        for (int i = 0; i < 20000; i++) begin
            if (sup_left > 0) begin
                sup_left--;
                if (sup_left == 0) supply_ok = 1'b1;
            end else if ($urandom_range(2999) == 0) begin
                supply_ok = 1'b0;
                sup_left = $urandom_range(50, 1);
            end
            if ($urandom_range(1999) == 0) kick_src_sel = ~kick_src_sel;
            if ($urandom_range(29) == 0) kick_pin = ~kick_pin;
            step(1);
        end
        checking = 1'b0;
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R3: run hung, finished=0 expected 1");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule